// File: doc/BRIEF.md
# ADC Sample/Convert Sequencer

This block is the digital timing core that sits beside a successive-approximation converter with up to four sample-and-hold channels. It divides the system clock into a converter clock enable (the TAD tick). Once enabled, it opens a sampling window on every active channel. In auto-convert mode it closes that window after a programmed number of TAD periods. It then hands the held channels to the converter one at a time.

A conversion-done pulse from the converter model ends each conversion. On that pulse the block emits a result strobe tagged with the channel number and starts the next channel at once. After the last channel it reopens sampling without a gap, so that acquisition and conversion run back to back. An interrupt pulse marks every Nth result, where N is programmable.

The configuration inputs are expected to stay constant while the block is enabled. Dropping the enable input abandons any work in progress within one clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While enabled, `tad_tick` pulses once every `cfg_div`+1 clocks. Its phase restarts at the start of each sampling window, and the last clock of the window carries a tick. It is never high while the block is idle.
- R2: A sampling window holds every active channel's `sample_ch` bit high for exactly max(`cfg_samc`,1)×(`cfg_div`+1) clocks. The first conversion strobe follows in the next clock.
- R3: With `cfg_trig` at any value other than 3'b111, the sampling window never ends and no conversion strobe is issued. 3'b111 selects auto-convert.
- R4: `cfg_chps` sets the number of active channels: 2'b00 gives 1 (channel 0), 2'b01 gives 2 (channels 0–1), and 2'b10 or 2'b11 give 4.
  - Bit i of `sample_ch` and `conv_start` belongs to channel i.
  - `conv_start` is a one-clock, one-hot pulse that visits the active channels in ascending order.
  - The converting channel's `sample_ch` bit is low.
  - The other active channels keep acquiring.
  - Inactive channels never acquire.
- R5: A `conv_done` pulse during a conversion produces, one clock later, `res_valid` with `res_tag` equal to the converting channel's number. In that same clock the next channel's `conv_start` is issued, or, after the last channel, a new sampling window has begun.
- R6: `irq` is high only together with `res_valid`, on every (`cfg_smpi`+1)-th result since enable. The count wraps with no gap.
- R7: One clock after `enable` is low, every output is low. A later enable starts over with a fresh sampling window, channel 0 and a zero result count.
- R8: During reset every output is low.
- R9: `conv_done` outside a conversion is ignored: it yields no result and does not shorten sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low aborts to idle |
| cfg_trig | input | 3 | Sampling end source; 3'b111 = auto-convert |
| cfg_samc | input | 5 | Sampling window length in TAD (0 acts as 1) |
| cfg_chps | input | 2 | Active channel count code |
| cfg_smpi | input | 4 | Results per interrupt minus one |
| cfg_div | input | 6 | TAD divider; TAD = cfg_div+1 clocks |
| conv_done | input | 1 | Converter finished the current channel |
| tad_tick | output | 1 | Converter clock enable |
| sample_ch | output | 4 | Per-channel acquire level |
| conv_start | output | 4 | Per-channel conversion start pulse |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 2 | Channel number of the result |
| irq | output | 1 | Interrupt pulse |

## Verification
The bound checker watches these properties on every clock:
- the one-hot start pulse, and that the converting channel is not also acquiring;
- that no inactive channel acquires and that tags stay within range;
- that an interrupt only rides on a result, that manual-trigger mode never converts, and that disabling clears all outputs.

Window lengths, tick placement, channel and tag order, and the interrupt period all depend on the configuration. They only show in the bench's sweep over channel counts, sample times, dividers and interrupt periods, with a converter model that answers after 12 TAD.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_seq_tad.sv
module adc_seq_tad #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_lim,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tad_t;

    tad_t q, d;

    assign tick = run && (q.cnt == div_lim);

    always_comb begin
        d = q;
        if (clr || !run) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_seq_irqcnt.sv
module adc_seq_irqcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } irq_t;

    irq_t q, d;

    assign irq = q.irq;

    always_comb begin
        d = q;
        d.irq = 1'b0;
        if (clr) begin
            d.cnt = '0;
        end else if (step) begin
            if (q.cnt >= limit) begin
                d.cnt = '0;
                d.irq = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_MAX = 4,
    parameter int SAMC_W = 5,
    parameter int DIV_W  = 6,
    parameter int SMPI_W = 4,
    parameter int TRIG_W = 3,
    localparam int TAG_W = (CH_MAX > 1) ? $clog2(CH_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TRIG_W-1:0] cfg_trig,
    input  logic [SAMC_W-1:0] cfg_samc,
    input  logic [1:0]        cfg_chps,
    input  logic [SMPI_W-1:0] cfg_smpi,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              conv_done,
    output logic              tad_tick,
    output logic [CH_MAX-1:0] sample_ch,
    output logic [CH_MAX-1:0] conv_start,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic              irq
);
    localparam logic [TRIG_W-1:0] AUTO_CODE = {TRIG_W{1'b1}};
    localparam logic [CH_MAX-1:0] ONE_HOT0  = {{(CH_MAX-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e        state;
        logic [SAMC_W-1:0] scnt;
        logic [TAG_W-1:0]  cur;
        logic [CH_MAX-1:0] cstart;
        logic              rvalid;
        logic [TAG_W-1:0]  rtag;
    } seq_t;

    seq_t q, d;

    logic [TAG_W-1:0]  ch_last;
    logic [CH_MAX-1:0] ch_mask;
    logic [SAMC_W-1:0] samc_eff;
    logic              enter_samp;
    logic              accept;
    logic              tick;

    // active channel count decode
    always_comb begin
        if (cfg_chps == 2'b00)                   ch_last = '0;
        else if (cfg_chps == 2'b01 && CH_MAX > 2) ch_last = TAG_W'(1);
        else                                     ch_last = TAG_W'(CH_MAX - 1);
    end

    for (genvar i = 0; i < CH_MAX; i++) begin : g_mask
        assign ch_mask[i] = (TAG_W'(i) <= ch_last);
    end

    assign samc_eff = (cfg_samc == '0) ? SAMC_W'(1) : cfg_samc;

    adc_seq_tad #(.DIV_W(DIV_W)) u_tad (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.state != ST_IDLE),
        .clr     (enter_samp || !enable),
        .div_lim (cfg_div),
        .tick    (tick)
    );

    adc_seq_irqcnt #(.CNT_W(SMPI_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable),
        .step  (accept),
        .limit (cfg_smpi),
        .irq   (irq)
    );

    always_comb begin
        d          = q;
        d.cstart   = '0;
        d.rvalid   = 1'b0;
        enter_samp = 1'b0;
        accept     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (enable) begin
                    d.state    = ST_SAMP;
                    d.scnt     = '0;
                    d.cur      = '0;
                    enter_samp = 1'b1;
                end
            end
            ST_SAMP: begin
                if (tick) begin
                    if (q.scnt >= samc_eff - 1'b1) begin
                        if (cfg_trig == AUTO_CODE) begin
                            d.state  = ST_CONV;
                            d.scnt   = '0;
                            d.cur    = '0;
                            d.cstart = ONE_HOT0;
                        end
                    end else begin
                        d.scnt = q.scnt + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    accept   = 1'b1;
                    d.rvalid = 1'b1;
                    d.rtag   = q.cur;
                    if (q.cur >= ch_last) begin
                        d.state    = ST_SAMP;
                        d.scnt     = '0;
                        d.cur      = '0;
                        enter_samp = 1'b1;
                    end else begin
                        d.cur    = q.cur + 1'b1;
                        d.cstart = ONE_HOT0 << (q.cur + 1'b1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (!enable) begin
            d          = '0;
            enter_samp = 1'b0;
            accept     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (q.state)
            ST_SAMP: sample_ch = ch_mask;
            ST_CONV: sample_ch = ch_mask & ~(ONE_HOT0 << q.cur);
            default: sample_ch = '0;
        endcase
    end

    assign tad_tick   = tick;
    assign conv_start = q.cstart;
    assign res_valid  = q.rvalid;
    assign res_tag    = q.rtag;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int CH_MAX = 4,
    parameter int TRIG_W = 3,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [TRIG_W-1:0] cfg_trig,
    input logic [1:0]        cfg_chps,
    input logic              tad_tick,
    input logic [CH_MAX-1:0] sample_ch,
    input logic [CH_MAX-1:0] conv_start,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic              irq
);
    logic [CH_MAX-1:0] act_mask;
    int                act_n;

    always_comb begin
        act_n = (cfg_chps == 2'b00) ? 1 : (cfg_chps == 2'b01 && CH_MAX > 2) ? 2 : CH_MAX;
        for (int i = 0; i < CH_MAX; i++) act_mask[i] = (i < act_n);
    end

    // R4: one channel starts at a time
    a_r4_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conv_start));

    // R4: the channel being started is not acquiring
    a_r4_start_not_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ch & conv_start) == '0);

    // R4: inactive channels stay quiet
    a_r4_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((sample_ch | conv_start) & ~act_mask) == '0);

    // R5: tag names an active channel
    a_r5_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (int'(res_tag) < act_n));

    // R6: interrupt only with a result
    a_r6_irq_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> res_valid);

    // R3: manual trigger code never converts
    a_r3_manual_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_trig != {TRIG_W{1'b1}}) |-> (conv_start == '0));

    // R7, R1: dropping enable idles everything one clock later
    a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sample_ch == '0 && conv_start == '0 && !res_valid && !irq && !tad_tick));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CH_MAX (CH_MAX),
    .TRIG_W (TRIG_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_trig   (cfg_trig),
    .cfg_chps   (cfg_chps),
    .tad_tick   (tad_tick),
    .sample_ch  (sample_ch),
    .conv_start (conv_start),
    .res_valid  (res_valid),
    .res_tag    (res_tag),
    .irq        (irq)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] cfg_trig = 3'b111;
    logic [4:0] cfg_samc = 5'd2;
    logic [1:0] cfg_chps = 2'b00;
    logic [3:0] cfg_smpi = 4'd0;
    logic [5:0] cfg_div  = 6'd0;
    logic       model_done = 1'b0;
    logic       inj_done = 1'b0;
    wire        conv_done = model_done | inj_done;
    logic       tad_tick;
    logic [3:0] sample_ch;
    logic [3:0] conv_start;
    logic       res_valid;
    logic [1:0] res_tag;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // expectations for the running configuration
    bit mon_en = 0;
    int e_nch = 1, e_mask = 1, e_a = 1, e_s = 1, e_l = 1;
    int run = 0, exp_ch = 0, exp_tag = 0, nres = 0;
    bit busy = 0;
    int left = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_trig(cfg_trig), .cfg_samc(cfg_samc), .cfg_chps(cfg_chps),
        .cfg_smpi(cfg_smpi), .cfg_div(cfg_div), .conv_done(conv_done),
        .tad_tick(tad_tick), .sample_ch(sample_ch), .conv_start(conv_start),
        .res_valid(res_valid), .res_tag(res_tag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // converter model and monitor, acting on the falling edge
    always @(negedge clk) begin
        if (model_done) model_done = 1'b0;
        if (!enable) begin
            busy = 0;
        end else if (mon_en) begin
            chk((int'(sample_ch) & ~e_mask) == 0, "R4 inactive acquire", sample_ch, 0);
            if (int'(sample_ch) == e_mask) begin
                run++;
                chk(tad_tick == ((run % e_a) == 0), "R1 tick phase", tad_tick, (run % e_a) == 0);
            end
            if (res_valid) begin
                nres++;
                chk(int'(res_tag) == exp_tag, (nres == 1) ? "R7 restart tag" : "R5 tag order",
                    res_tag, exp_tag);
                chk(irq == ((nres % e_l) == 0), "R6 irq period", irq, (nres % e_l) == 0);
                if (exp_tag != e_nch - 1)
                    chk(int'(conv_start) == (1 << (exp_tag + 1)), "R5 next start", conv_start,
                        1 << (exp_tag + 1));
                else
                    chk(int'(sample_ch) == e_mask, "R5 resample", sample_ch, e_mask);
                exp_tag = (exp_tag + 1) % e_nch;
            end else begin
                chk(!irq, "R6 irq alone", irq, 0);
            end
            if (conv_start != 4'b0) begin
                if (exp_ch == 0) chk(run == e_s * e_a, "R2 window", run, e_s * e_a);
                run = 0;
                chk(int'(conv_start) == (1 << exp_ch), "R4 start order", conv_start, 1 << exp_ch);
                chk(int'(sample_ch) == (e_mask & ~(1 << exp_ch)), "R4 others acquire",
                    sample_ch, e_mask & ~(1 << exp_ch));
                exp_ch = (exp_ch + 1) % e_nch;
                busy = 1;
                left = 12;
            end else if (busy && tad_tick) begin
                left--;
                if (left == 0) begin
                    busy = 0;
                    model_done = 1'b1;
                end
            end
        end
    end

    task automatic run_cfg(input int chps, input int samc, input int dv, input int smpi, input int target);
        @(negedge clk);
        cfg_trig = 3'b111;
        cfg_chps = 2'(chps);
        cfg_samc = 5'(samc);
        cfg_div  = 6'(dv);
        cfg_smpi = 4'(smpi);
        e_nch  = (chps == 0) ? 1 : (chps == 1) ? 2 : 4;
        e_mask = (1 << e_nch) - 1;
        e_a    = dv + 1;
        e_s    = (samc == 0) ? 1 : samc;
        e_l    = smpi + 1;
        run = 0; exp_ch = 0; exp_tag = 0; nres = 0;
        mon_en = 1;
        enable = 1'b1;
        do @(posedge clk); while (nres < target);
        do @(posedge clk); while (!busy);
        repeat (3) @(posedge clk);
        @(negedge clk);
        enable = 1'b0;
        mon_en = 0;
        @(posedge clk);
        @(negedge clk);
        chk(sample_ch == 4'b0 && conv_start == 4'b0 && !res_valid && !irq && !tad_tick,
            "R7 abort idle", {sample_ch, conv_start, res_valid, irq, tad_tick}, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sample_ch == 4'b0 && conv_start == 4'b0 && !res_valid && !irq && !tad_tick,
            "R8 reset outputs", {sample_ch, conv_start, res_valid, irq, tad_tick}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 and R9: manual trigger code holds the window open; stray done is ignored
        begin
            bit saw_rv = 0, saw_cs = 0, all_samp = 1;
            cfg_trig = 3'b000; cfg_chps = 2'b01; cfg_samc = 5'd2; cfg_div = 6'd1;
            enable = 1'b1;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                inj_done = (k == 60);
                if (res_valid) saw_rv = 1;
                if (conv_start != 4'b0) saw_cs = 1;
                if (k > 0 && sample_ch != 4'b0011) all_samp = 0;
            end
            inj_done = 1'b0;
            chk(!saw_cs, "R3 no start", saw_cs, 0);
            chk(all_samp, "R3 window held", all_samp, 1);
            chk(!saw_rv, "R9 stray done", saw_rv, 0);
            enable = 1'b0;
            repeat (3) @(negedge clk);
        end

        // sweep: channel count x sample time x divider x interrupt period
        for (int c = 0; c < 3; c++)
            for (int s = 0; s < 4; s++)
                for (int dv = 0; dv < 3; dv++)
                    for (int m = 0; m < 3; m++)
                        run_cfg(c, (s == 3) ? 4 : s, (dv == 2) ? 3 : dv, (m == 2) ? 3 : m, 9);

        // R7 restart after an abort mid-count, same configuration twice
        run_cfg(2, 2, 1, 3, 2);
        run_cfg(2, 2, 1, 3, 6);

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule